// File: doc/BRIEF.md
# Bus-Mapped Control and Status Register Bank

This block is a Wishbone slave that puts three kinds of register behind one small address map: an 8-bit data bus and a 4-bit address. Read-only status words mirror values that other logic drives into the block. Read-write setting words drive configuration outputs and start from fixed default values after reset. Single-bit trigger flags are armed by a bus write and stay armed until the logic they start clears them through a dedicated clear input.

Each access that the slave accepts gets exactly one response cycle on the clock edge after acceptance. A mapped address gets an acknowledge and an unmapped address gets an error. Read data is registered together with the acknowledge. Retry is never used. A master holds cycle and strobe until it sees a response and then drops them. The block takes a new access only while it is not showing a response.

Top module: `cfg_regbank`

## Requirements
- R1: While rst_n is low and on release, wb_ack_o and wb_err_o are 0, all trigger flags are 0, and the setting outputs hold their defaults: 0x05 at address 0x6, 0x3C at address 0x7, 0xAA at address 0x8. Setting index i sits in setting_o[8*i+7:8*i].
- R2: When wb_cyc_i and wb_stb_i are both high at a clock edge, and neither wb_ack_o nor wb_err_o is high, the access is accepted. If its address is mapped, wb_ack_o is high for exactly the one cycle that follows. The read data for a read is valid in that same cycle.
- R3: The unmapped addresses are 0x3, 0x4, 0x5, 0x9, 0xD, 0xE and 0xF. An access to one of them raises wb_err_o instead of wb_ack_o for one cycle, returns read data 0x00 and changes no register.
- R4: wb_rty_o is always 0.
- R5: A read of address 0x0, 0x1 or 0x2 returns byte 0, 1 or 2 of status_i (status_i[8*i+7:8*i]), as sampled at the acceptance edge. A write to these addresses is acknowledged and has no effect.
- R6: A write to address 0x6, 0x7 or 0x8 loads the full data byte into that setting. The new value appears on setting_o from the acceptance edge, and a later read of the address returns it.
- R7: A write to 0xA, 0xB or 0xC with data bit 7 set arms trig_o[0], [1] or [2] respectively. With data bit 7 clear, the flag is left unchanged. The other data bits are ignored.
- R8: An armed trigger flag stays 1 on every edge at which its trig_clr_i bit is low. It goes to 0 on the first edge at which that bit is high.
- R9: If a write arms a trigger flag at the same edge at which its clear bit is high, the flag ends up 0.
- R10: A read of 0xA, 0xB or 0xC returns the flag in bit 7 and zeros in bits 6 to 0.
- R11: While wb_cyc_i is low, no access is accepted, even with wb_stb_i high. No response follows and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 4 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_ack_o | output | 1 | Acknowledge, one cycle |
| wb_err_o | output | 1 | Error for an unmapped address, one cycle |
| wb_rty_o | output | 1 | Retry, tied low |
| wb_dat_o | output | 8 | Read data, valid with acknowledge |
| status_i | input | 24 | Three status bytes from other logic |
| setting_o | output | 24 | Three configuration bytes |
| trig_o | output | 3 | Trigger flags |
| trig_clr_i | input | 3 | Per-flag clear from the launched process |

## Verification
A bus write that arms a trigger flag and the launched process clearing that same flag can fall on one clock edge. The bench provokes this by driving the arming write to 0xA and trig_clr_i[0] in the same cycle. It then checks that the flag reads 0 in the response cycle, while the write is still acknowledged. It also checks the ordinary arm, hold and clear sequence, so that a design giving the set priority, or one that never holds the flag, is told apart from a correct one.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_STAT = 2'd1,
        CLS_SET  = 2'd2,
        CLS_TRIG = 2'd3
    } reg_cls_e;

endpackage

// File: rtl/rbk_decode.sv
module rbk_decode
    import rbk_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int N_STAT    = 3,
    parameter int N_SET     = 3,
    parameter int N_TRIG    = 3,
    parameter int STAT_BASE = 0,
    parameter int SET_BASE  = 6,
    parameter int TRIG_BASE = 10
) (
    input  logic [ADDR_W-1:0] adr,
    output reg_cls_e          cls,
    output logic [ADDR_W-1:0] idx
);

    always_comb begin
        cls = CLS_NONE;
        idx = '0;
        for (int i = 0; i < N_STAT; i++) begin
            if (adr == ADDR_W'(STAT_BASE + i)) begin
                cls = CLS_STAT;
                idx = ADDR_W'(i);
            end
        end
        for (int i = 0; i < N_SET; i++) begin
            if (adr == ADDR_W'(SET_BASE + i)) begin
                cls = CLS_SET;
                idx = ADDR_W'(i);
            end
        end
        for (int i = 0; i < N_TRIG; i++) begin
            if (adr == ADDR_W'(TRIG_BASE + i)) begin
                cls = CLS_TRIG;
                idx = ADDR_W'(i);
            end
        end
    end

endmodule

// File: rtl/rbk_settings.sv
module rbk_settings #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int N_SET  = 3,
    parameter logic [N_SET*DATA_W-1:0] DEFAULTS = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    sel,
    input  logic [ADDR_W-1:0]       idx,
    input  logic [DATA_W-1:0]       wdat,
    output logic [N_SET*DATA_W-1:0] val
);

    typedef struct packed {
        logic [N_SET*DATA_W-1:0] regs;
    } set_state_t;

    set_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && sel) begin
            for (int i = 0; i < N_SET; i++) begin
                if (idx == ADDR_W'(i)) begin
                    st_d.regs[i*DATA_W +: DATA_W] = wdat;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs <= DEFAULTS;
        end else begin
            st_q <= st_d;
        end
    end

    assign val = st_q.regs;

endmodule

// File: rtl/rbk_triggers.sv
module rbk_triggers #(
    parameter int ADDR_W = 4,
    parameter int N_TRIG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [ADDR_W-1:0] idx,
    input  logic              arm_bit,
    input  logic [N_TRIG-1:0] clr,
    output logic [N_TRIG-1:0] flags
);

    typedef struct packed {
        logic [N_TRIG-1:0] flag;
    } trig_state_t;

    trig_state_t st_d, st_q;
    logic [N_TRIG-1:0] arm;

    for (genvar g = 0; g < N_TRIG; g++) begin : g_arm
        assign arm[g] = wr_en && sel && arm_bit && (idx == ADDR_W'(g));
    end

    always_comb begin
        st_d = st_q;
        // clear takes priority over a same-cycle arm
        st_d.flag = (st_q.flag | arm) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flag;

endmodule

// File: rtl/rbk_bus_ctl.sv
module rbk_bus_ctl
    import rbk_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int N_STAT   = 3,
    parameter int N_SET    = 3,
    parameter int N_TRIG   = 3,
    parameter int TRIG_BIT = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     we,
    input  reg_cls_e                 cls,
    input  logic [ADDR_W-1:0]        idx,
    input  logic [N_STAT*DATA_W-1:0] stat_vec,
    input  logic [N_SET*DATA_W-1:0]  set_vec,
    input  logic [N_TRIG-1:0]        trig_vec,
    output logic                     wr_en,
    output logic                     ack,
    output logic                     err,
    output logic [DATA_W-1:0]        rdat
);

    typedef struct packed {
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdat;
    } bus_state_t;

    bus_state_t st_d, st_q;
    logic accept;
    logic mapped;
    logic [DATA_W-1:0] mux_rd;

    assign accept = req && !st_q.ack && !st_q.err;
    assign mapped = (cls != CLS_NONE);
    assign wr_en  = accept && we && mapped;

    always_comb begin
        mux_rd = '0;
        for (int i = 0; i < N_STAT; i++) begin
            if (cls == CLS_STAT && idx == ADDR_W'(i)) begin
                mux_rd = stat_vec[i*DATA_W +: DATA_W];
            end
        end
        for (int i = 0; i < N_SET; i++) begin
            if (cls == CLS_SET && idx == ADDR_W'(i)) begin
                mux_rd = set_vec[i*DATA_W +: DATA_W];
            end
        end
        for (int i = 0; i < N_TRIG; i++) begin
            if (cls == CLS_TRIG && idx == ADDR_W'(i)) begin
                mux_rd = '0;
                mux_rd[TRIG_BIT] = trig_vec[i];
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.ack  = accept && mapped;
        st_d.err  = accept && !mapped;
        st_d.rdat = (accept && mapped && !we) ? mux_rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack  = st_q.ack;
    assign err  = st_q.err;
    assign rdat = st_q.rdat;

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import rbk_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int N_STAT    = 3,
    parameter int N_SET     = 3,
    parameter int N_TRIG    = 3,
    parameter int STAT_BASE = 0,
    parameter int SET_BASE  = 6,
    parameter int TRIG_BASE = 10,
    parameter int TRIG_BIT  = 7,
    parameter logic [N_SET*DATA_W-1:0] SET_DEFAULTS = 24'hAA3C05
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wb_cyc_i,
    input  logic                     wb_stb_i,
    input  logic                     wb_we_i,
    input  logic [ADDR_W-1:0]        wb_adr_i,
    input  logic [DATA_W-1:0]        wb_dat_i,
    output logic                     wb_ack_o,
    output logic                     wb_err_o,
    output logic                     wb_rty_o,
    output logic [DATA_W-1:0]        wb_dat_o,
    input  logic [N_STAT*DATA_W-1:0] status_i,
    output logic [N_SET*DATA_W-1:0]  setting_o,
    output logic [N_TRIG-1:0]        trig_o,
    input  logic [N_TRIG-1:0]        trig_clr_i
);

    reg_cls_e          cls;
    logic [ADDR_W-1:0] idx;
    logic              wr_en;
    logic              req;

    assign req      = wb_cyc_i && wb_stb_i;
    assign wb_rty_o = 1'b0;

    rbk_decode #(
        .ADDR_W(ADDR_W), .N_STAT(N_STAT), .N_SET(N_SET), .N_TRIG(N_TRIG),
        .STAT_BASE(STAT_BASE), .SET_BASE(SET_BASE), .TRIG_BASE(TRIG_BASE)
    ) dec_i (
        .adr(wb_adr_i),
        .cls(cls),
        .idx(idx)
    );

    rbk_bus_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_STAT(N_STAT), .N_SET(N_SET),
        .N_TRIG(N_TRIG), .TRIG_BIT(TRIG_BIT)
    ) ctl_i (
        .clk(clk),
        .rst_n(rst_n),
        .req(req),
        .we(wb_we_i),
        .cls(cls),
        .idx(idx),
        .stat_vec(status_i),
        .set_vec(setting_o),
        .trig_vec(trig_o),
        .wr_en(wr_en),
        .ack(wb_ack_o),
        .err(wb_err_o),
        .rdat(wb_dat_o)
    );

    rbk_settings #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SET(N_SET), .DEFAULTS(SET_DEFAULTS)
    ) set_i (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .sel(cls == CLS_SET),
        .idx(idx),
        .wdat(wb_dat_i),
        .val(setting_o)
    );

    rbk_triggers #(
        .ADDR_W(ADDR_W), .N_TRIG(N_TRIG)
    ) trg_i (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .sel(cls == CLS_TRIG),
        .idx(idx),
        .arm_bit(wb_dat_i[TRIG_BIT]),
        .clr(trig_clr_i),
        .flags(trig_o)
    );

endmodule

// File: rtl/cfg_regbank_checker.sv
module cfg_regbank_checker #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int N_STAT    = 3,
    parameter int N_SET     = 3,
    parameter int N_TRIG    = 3,
    parameter int STAT_BASE = 0,
    parameter int SET_BASE  = 6,
    parameter int TRIG_BASE = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cyc,
    input logic                    stb,
    input logic                    we,
    input logic [ADDR_W-1:0]       adr,
    input logic                    ack,
    input logic                    err,
    input logic                    rty,
    input logic [N_SET*DATA_W-1:0] set_out,
    input logic [N_TRIG-1:0]       trig,
    input logic [N_TRIG-1:0]       trig_clr
);

    function automatic logic in_map(input logic [ADDR_W-1:0] a);
        int v;
        v = int'(a);
        return (v >= STAT_BASE && v < STAT_BASE + N_STAT) ||
               (v >= SET_BASE  && v < SET_BASE  + N_SET)  ||
               (v >= TRIG_BASE && v < TRIG_BASE + N_TRIG);
    endfunction

    logic take;
    assign take = cyc && stb && !ack && !err;

    p_ack_mapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_map(adr)) |=> (ack && !err));

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_err_unmapped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_map(adr)) |=> (err && !ack));

    p_err_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_map(adr)) |=> $stable(set_out));

    p_rty_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rty);

    p_set_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc && stb && we) |=> $stable(set_out));

    p_trig_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(trig) & ~$past(trig_clr) & ~trig) == '0));

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((trig & $past(trig_clr)) == '0));

    p_no_cyc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc && !ack && !err) |=> (!ack && !err));

endmodule

bind cfg_regbank cfg_regbank_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_STAT(N_STAT), .N_SET(N_SET),
    .N_TRIG(N_TRIG), .STAT_BASE(STAT_BASE), .SET_BASE(SET_BASE),
    .TRIG_BASE(TRIG_BASE)
) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .cyc(wb_cyc_i),
    .stb(wb_stb_i),
    .we(wb_we_i),
    .adr(wb_adr_i),
    .ack(wb_ack_o),
    .err(wb_err_o),
    .rty(wb_rty_o),
    .set_out(setting_o),
    .trig(trig_o),
    .trig_clr(trig_clr_i)
);

// File: tb/cfg_regbank_tb.sv
module cfg_regbank_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [3:0]  adr = '0;
    logic [7:0]  wdat = '0;
    logic        ack, err, rty;
    logic [7:0]  rdat;
    logic [23:0] status = '0;
    logic [23:0] setting;
    logic [2:0]  trig;
    logic [2:0]  trig_clr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] set_m [3];
    logic [2:0] trig_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_regbank dut_i (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat),
        .wb_ack_o(ack), .wb_err_o(err), .wb_rty_o(rty), .wb_dat_o(rdat),
        .status_i(status), .setting_o(setting),
        .trig_o(trig), .trig_clr_i(trig_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_mapped(input int a);
        return (a <= 2) || (a >= 6 && a <= 8) || (a >= 10 && a <= 12);
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        if (a <= 2) return status[a*8 +: 8];
        if (a >= 6 && a <= 8) return set_m[a-6];
        if (a >= 10 && a <= 12) return {trig_m[a-10], 7'b0};
        return 8'h00;
    endfunction

    function automatic logic [23:0] set_flat();
        return {set_m[2], set_m[1], set_m[0]};
    endfunction

    // one access; response sampled at the negedge after the acceptance edge
    task automatic access(input logic w, input int a, input logic [7:0] d,
                          output logic r_ack, output logic r_err, output logic [7:0] r_dat);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = 4'(a); wdat = d;
        @(posedge clk);
        @(negedge clk);
        r_ack = ack; r_err = err; r_dat = rdat;
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a >= 6 && a <= 8) set_m[a-6] = d;
        if (a >= 10 && a <= 12 && d[7]) trig_m[a-10] = 1'b1;
    endtask

    task automatic read_sweep(input string tag);
        logic a_, e_; logic [7:0] d_;
        for (int a = 0; a < 16; a++) begin
            access(1'b0, a, 8'h00, a_, e_, d_);
            check({tag, " R2 ack"}, 32'(a_), 32'(is_mapped(a)));
            check({tag, " R3 err"}, 32'(e_), 32'(!is_mapped(a)));
            check({tag, " R5/R6/R10 rdata"}, 32'(d_), 32'(exp_read(a)));
            check({tag, " R4 rty"}, 32'(rty), 32'h0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic a_, e_; logic [7:0] d_;
        set_m[0] = 8'h05; set_m[1] = 8'h3C; set_m[2] = 8'hAA;
        trig_m = '0;
        status = 24'h01C35A;

        repeat (3) @(negedge clk);
        check("R1 ack in reset", 32'(ack), 0);
        check("R1 err in reset", 32'(err), 0);
        check("R1 defaults in reset", 32'(setting), 32'h00AA3C05);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 defaults after release", 32'(setting), 32'h00AA3C05);
        check("R1 triggers", 32'(trig), 0);

        read_sweep("sweep1");

        // response lasts one cycle
        access(1'b0, 6, 8'h00, a_, e_, d_);
        @(negedge clk);
        check("R2 ack one cycle", 32'(ack), 0);

        // setting writes across several patterns
        for (int i = 0; i < 3; i++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] v;
                v = 8'((i * 83 + p * 61 + 17) ^ (p == 3 ? 255 : 0));
                if (p == 0) v = 8'h00;
                if (p == 1) v = 8'hFF;
                access(1'b1, 6 + i, v, a_, e_, d_);
                model_write(6 + i, v);
                check("R6 write ack", 32'(a_), 1);
                check("R6 setting_o", 32'(setting), 32'(set_flat()));
                access(1'b0, 6 + i, 8'h00, a_, e_, d_);
                check("R6 readback", 32'(d_), 32'(v));
            end
        end

        // status writes ignored
        for (int a = 0; a < 3; a++) begin
            access(1'b1, a, 8'hFF, a_, e_, d_);
            check("R5 status write ack", 32'(a_), 1);
            check("R5 status write no setting change", 32'(setting), 32'(set_flat()));
        end
        status = 24'h7E0F80;
        read_sweep("sweep2");

        // unmapped writes
        for (int a = 0; a < 16; a++) begin
            if (!is_mapped(a)) begin
                access(1'b1, a, 8'hFF, a_, e_, d_);
                check("R3 unmapped write err", 32'(e_), 1);
                check("R3 unmapped write ack", 32'(a_), 0);
                check("R3 no change settings", 32'(setting), 32'(set_flat()));
                check("R3 no change triggers", 32'(trig), 0);
            end
        end

        // trigger arming
        access(1'b1, 11, 8'h7F, a_, e_, d_);
        check("R7 bit7 clear leaves flag", 32'(trig), 0);
        access(1'b1, 10, 8'h80, a_, e_, d_);
        model_write(10, 8'h80);
        check("R7 arm flag 0", 32'(trig), 32'h1);
        access(1'b1, 12, 8'hFF, a_, e_, d_);
        model_write(12, 8'hFF);
        check("R7 arm flag 2", 32'(trig), 32'h5);
        access(1'b1, 10, 8'h00, a_, e_, d_);
        check("R7 zero write keeps flag", 32'(trig), 32'h5);
        read_sweep("sweep3");

        repeat (6) @(negedge clk);
        check("R8 flags held", 32'(trig), 32'h5);
        trig_clr = 3'b001;
        @(negedge clk);
        trig_clr = 3'b000;
        trig_m[0] = 1'b0;
        check("R8 clear flag 0", 32'(trig), 32'h4);
        @(negedge clk);
        check("R8 flag 2 still held", 32'(trig), 32'h4);

        // same-cycle arm and clear
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 4'hA; wdat = 8'h80;
        trig_clr = 3'b001;
        @(posedge clk);
        @(negedge clk);
        check("R9 write still acked", 32'(ack), 1);
        check("R9 clear wins", 32'(trig), 32'h4);
        cyc = 1'b0; stb = 1'b0; we = 1'b0; trig_clr = 3'b000;
        access(1'b0, 10, 8'h00, a_, e_, d_);
        check("R10 read cleared flag", 32'(d_), 32'h00);
        access(1'b0, 12, 8'h00, a_, e_, d_);
        check("R10 read armed flag", 32'(d_), 32'h80);

        // strobe without cycle
        @(negedge clk);
        cyc = 1'b0; stb = 1'b1; we = 1'b1; adr = 4'h7; wdat = 8'h99;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R11 no ack without cyc", 32'(ack), 0);
            check("R11 no err without cyc", 32'(err), 0);
        end
        check("R11 setting unchanged", 32'(setting), 32'(set_flat()));
        stb = 1'b0; we = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule